// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Engine

This block sits between a CPU register port and a parallel ATA bus run in True-IDE mode. It drives programmed-I/O cycles only. A CPU write to one of the task-file or data offsets goes into a small command queue. When the interface is enabled, the engine takes each queued command and plays it out as one ATA write cycle. A CPU read of one of those offsets does not return device data. It queues a read cycle instead. When that cycle finishes, the captured value is held in a read-result register, and software fetches it with a second read.

Every cycle runs through three phases: address setup with a chip select and DA driven, strobe active, and recovery with the bus idle. The length of each phase comes from a packed timing register. The strobe phase can be stretched by the device through IORDY. Software has no back-pressure signal on the register port. Before each access it polls a busy nibble until it reads zero, and an access that arrives while the queue is full is dropped. An interrupt status register with write-1-to-clear bits latches the device interrupt line and cycle completion. A mask register selects which of these bits drive the single interrupt output.

Top module: `pio_host_engine`

## Requirements
- R1: After reset, both chip selects and both strobes are high, `ata_dd_oe` is low, `irq` is low, the status word (offset 0x90) and the interrupt status (0x10) read 0, and the mask (0x14) reads all ones.
- R2: A CPU write to offset 0x54+4n (n = 0..7) queues a write cycle on chip select 0 with DA = n, and a write to 0x74 queues one on chip select 1 with DA = 6. Offset 0x54 is the 16-bit data port. Every other offset is an 8-bit access that drives the low byte of the written value and 0 on DD[15:8].
- R3: With timing register (0x2C) fields setup [3:0], active [11:4] and recovery [19:12], each phase lasts that many clocks, and a field of 0 counts as 1. When cycles run back to back, the idle gap between them is recovery + 1 clocks.
- R4: A CPU read of a task-file or data offset returns 0 and queues a read cycle. After that cycle, offset 0x7C returns the captured value: an 8-bit access returns DD[7:0] zero-extended, and a data-port access returns 16 bits.
- R5: Configuration bit 6 (offset 0x18) clear swaps the two bytes of 16-bit data in both directions. Bit 6 set passes 16-bit data straight through.
- R6: With configuration bit 1 set, the strobe stays asserted past its programmed count for as long as IORDY is low. With bit 1 clear, IORDY is ignored.
- R7: Bits [31:28] of the status word at 0x90 hold the number of accesses that are queued or in progress. The field is 0 only when the engine is idle.
- R8: Control bit 0 (offset 0x00) enables the interface. While it is clear, no cycle starts and accepted accesses stay queued.
- R9: The queue holds 4 accesses. An access that arrives while the queue is full is discarded.
- R10: In interrupt status (0x10), bit 0 is set while `ata_intrq` is high and bit 1 is set when a cycle completes. Both bits are cleared by writing 1. `irq` is high when a status bit is set and its mask bit is 0.
- R11: On a write, DD is driven from strobe assertion until one clock after the strobe deasserts. DD is never driven during a read strobe, and read data is latched on the edge at which the read strobe deasserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus out |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus in |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |
| ata_intrq | input | 1 | Device interrupt request |
| irq | output | 1 | Masked interrupt to the CPU |

## Verification
A phase counter that loads the wrong value shows up at once as a setup or strobe width that differs from the programmed count, and this happens on the very first cycle after the timing register is written. A queue pointer or occupancy error shows up as a busy nibble that never reaches zero, or as a cycle carrying the wrong address or data. The scoreboard catches that cycle at the strobe edge where it occurs. A stuck enable or IORDY path is visible within one access as a missing strobe or a strobe of the wrong length. A hold flag that stays set shows up as a data bus still driven on the clock after the write strobe ends.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFF_CTRL   = 8'h00;
  localparam logic [REG_AW-1:0] OFF_ISTAT  = 8'h10;
  localparam logic [REG_AW-1:0] OFF_IMASK  = 8'h14;
  localparam logic [REG_AW-1:0] OFF_CFG    = 8'h18;
  localparam logic [REG_AW-1:0] OFF_TIMING = 8'h2C;
  localparam logic [REG_AW-1:0] OFF_DATA   = 8'h54;
  localparam logic [REG_AW-1:0] OFF_ALTCTL = 8'h74;
  localparam logic [REG_AW-1:0] OFF_RESULT = 8'h7C;
  localparam logic [REG_AW-1:0] OFF_STATUS = 8'h90;

  typedef struct packed {
    logic        wr;
    logic        cs1;
    logic [2:0]  da;
    logic        wide;
    logic [15:0] data;
  } pio_cmd_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;
endpackage

// File: rtl/pio_cmd_fifo.sv
module pio_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 22,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end
endmodule

// File: rtl/pio_cycle_ctl.sv
module pio_cycle_ctl
  import pio_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int ACT_W = 8,
  parameter int REC_W = 8,
  localparam int MX1  = (SET_W > ACT_W) ? SET_W : ACT_W,
  localparam int CNT_W = (MX1 > REC_W) ? MX1 : REC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  pio_cmd_t         cmd,
  input  logic [SET_W-1:0] t_setup,
  input  logic [ACT_W-1:0] t_active,
  input  logic [REC_W-1:0] t_recov,
  input  logic             iordy_en,
  input  logic             iordy,
  input  logic [15:0]      dd_in,
  output logic             take,
  output logic             busy,
  output logic             done,
  output logic             cs0_n,
  output logic             cs1_n,
  output logic [2:0]       da,
  output logic             dior_n,
  output logic             diow_n,
  output logic [15:0]      dd_out,
  output logic             dd_oe,
  output logic             rd_valid,
  output logic             rd_wide,
  output logic [15:0]      rd_data
);
  pio_phase_e       phase;
  pio_cmd_t         cur;
  logic [CNT_W-1:0] cnt, len_s, len_a, len_r;
  logic             hold;
  logic             addr_phase, last;

  // a zero count still lasts one clock
  assign len_s = (t_setup  == '0) ? CNT_W'(1) : CNT_W'(t_setup);
  assign len_a = (t_active == '0) ? CNT_W'(1) : CNT_W'(t_active);
  assign len_r = (t_recov  == '0) ? CNT_W'(1) : CNT_W'(t_recov);

  assign last       = (cnt == CNT_W'(1));
  assign take       = (phase == PH_IDLE) && start;
  assign busy       = (phase != PH_IDLE);
  assign done       = (phase == PH_RECOV) && last;
  assign addr_phase = (phase == PH_SETUP) || (phase == PH_ACTIVE);

  assign cs0_n  = !(addr_phase && !cur.cs1);
  assign cs1_n  = !(addr_phase &&  cur.cs1);
  assign da     = cur.da;
  assign dior_n = !((phase == PH_ACTIVE) && !cur.wr);
  assign diow_n = !((phase == PH_ACTIVE) &&  cur.wr);
  assign dd_out = cur.data;
  assign dd_oe  = ((phase == PH_ACTIVE) && cur.wr) || ((phase == PH_RECOV) && hold);
  assign rd_wide = cur.wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cur      <= '0;
      cnt      <= '0;
      hold     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          cur   <= cmd;
          cnt   <= len_s;
          phase <= PH_SETUP;
        end
        PH_SETUP: if (last) begin
          cnt   <= len_a;
          phase <= PH_ACTIVE;
        end else cnt <= cnt - 1'b1;
        PH_ACTIVE: if (!last) cnt <= cnt - 1'b1;
        else if (!iordy_en || iordy) begin
          cnt   <= len_r;
          phase <= PH_RECOV;
          hold  <= cur.wr;
          if (!cur.wr) begin
            rd_data  <= dd_in;
            rd_valid <= 1'b1;
          end
        end
        PH_RECOV: begin
          hold <= 1'b0;
          if (last) phase <= PH_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_int_ctl.sv
module pio_int_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
        mask[i]   <= 1'b1;
      end else begin
        if (set[i])                      status[i] <= 1'b1;
        else if (clr_we && wdata[i])     status[i] <= 1'b0;
        if (mask_we)                     mask[i]   <= wdata[i];
      end
    end
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/pio_host_engine.sv
module pio_host_engine
  import pio_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int SET_W  = 4,
  parameter int ACT_W  = 8,
  parameter int REC_W  = 8,
  localparam int TIM_W = SET_W + ACT_W + REC_W,
  localparam int CMD_W = $bits(pio_cmd_t),
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ata_cs0_n,
  output logic        ata_cs1_n,
  output logic [2:0]  ata_da,
  output logic        ata_dior_n,
  output logic        ata_diow_n,
  output logic [15:0] ata_dd_out,
  output logic        ata_dd_oe,
  input  logic [15:0] ata_dd_in,
  input  logic        ata_iordy,
  input  logic        ata_intrq,
  output logic        irq
);
  logic             ctrl_en, cfg_iordy, cfg_noswap;
  logic [TIM_W-1:0] timing;
  logic [31:0]      result;
  logic [31:0]      occ;
  logic [3:0]       busy_nib;
  logic [1:0]       int_stat, int_mask;
  logic             is_tf, q_push, q_full, q_empty, eng_take, eng_busy, eng_done;
  logic             rd_valid, rd_wide;
  logic [15:0]      rd_data, wdata16;
  logic [7:0]       tf_off;
  logic [QCW-1:0]   q_count;
  pio_cmd_t         new_cmd, head_cmd;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[31:TIM_W];

  // task-file window: word offsets from the data port up to the control block
  assign tf_off = bus_addr - OFF_DATA;
  assign is_tf  = (bus_addr >= OFF_DATA) && (bus_addr <= OFF_ALTCTL) && (bus_addr[1:0] == 2'b00);
  assign wdata16 = cfg_noswap ? bus_wdata[15:0] : {bus_wdata[7:0], bus_wdata[15:8]};

  always_comb begin
    new_cmd.wr   = bus_wr;
    new_cmd.cs1  = (bus_addr == OFF_ALTCTL);
    new_cmd.da   = (bus_addr == OFF_ALTCTL) ? 3'd6 : tf_off[4:2];
    new_cmd.wide = (bus_addr == OFF_DATA);
    new_cmd.data = (bus_addr == OFF_DATA) ? wdata16 : {8'h00, bus_wdata[7:0]};
  end

  assign q_push = bus_sel && is_tf && !q_full;

  pio_cmd_fifo #(.DEPTH(QDEPTH), .W(CMD_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(new_cmd),
    .pop(eng_take), .dout(head_cmd), .full(q_full), .empty(q_empty), .count(q_count)
  );

  pio_cycle_ctl #(.SET_W(SET_W), .ACT_W(ACT_W), .REC_W(REC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(!q_empty && ctrl_en), .cmd(head_cmd),
    .t_setup(timing[SET_W-1:0]),
    .t_active(timing[SET_W+ACT_W-1:SET_W]),
    .t_recov(timing[TIM_W-1:SET_W+ACT_W]),
    .iordy_en(cfg_iordy), .iordy(ata_iordy), .dd_in(ata_dd_in),
    .take(eng_take), .busy(eng_busy), .done(eng_done),
    .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n), .da(ata_da),
    .dior_n(ata_dior_n), .diow_n(ata_diow_n),
    .dd_out(ata_dd_out), .dd_oe(ata_dd_oe),
    .rd_valid(rd_valid), .rd_wide(rd_wide), .rd_data(rd_data)
  );

  pio_int_ctl #(.N(2)) u_int (
    .clk(clk), .rst_n(rst_n), .set({eng_done, ata_intrq}),
    .clr_we(bus_sel && bus_wr && (bus_addr == OFF_ISTAT)),
    .mask_we(bus_sel && bus_wr && (bus_addr == OFF_IMASK)),
    .wdata(bus_wdata[1:0]), .status(int_stat), .mask(int_mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      cfg_iordy  <= 1'b0;
      cfg_noswap <= 1'b0;
      timing     <= '0;
      result     <= '0;
    end else begin
      if (bus_sel && bus_wr) begin
        unique case (bus_addr)
          OFF_CTRL:   ctrl_en <= bus_wdata[0];
          OFF_CFG: begin
            cfg_iordy  <= bus_wdata[1];
            cfg_noswap <= bus_wdata[6];
          end
          OFF_TIMING: timing <= bus_wdata[TIM_W-1:0];
          default: ;
        endcase
      end
      if (rd_valid)
        result <= rd_wide ? {16'h0, cfg_noswap ? rd_data : {rd_data[7:0], rd_data[15:8]}}
                          : {24'h0, rd_data[7:0]};
    end
  end

  assign occ      = 32'(q_count) + {31'h0, eng_busy};
  assign busy_nib = (occ > 32'd15) ? 4'hF : occ[3:0];

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL:   bus_rdata = {31'h0, ctrl_en};
      OFF_ISTAT:  bus_rdata = {30'h0, int_stat};
      OFF_IMASK:  bus_rdata = {30'h0, int_mask};
      OFF_CFG:    bus_rdata = {25'h0, cfg_noswap, 4'h0, cfg_iordy, 1'b0};
      OFF_TIMING: bus_rdata = 32'(timing);
      OFF_RESULT: bus_rdata = result;
      OFF_STATUS: bus_rdata = {busy_nib, 28'h0};
      default:    bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/pio_host_engine_chk.sv
module pio_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs0_n,
  input logic       cs1_n,
  input logic       dior_n,
  input logic       diow_n,
  input logic       dd_oe,
  input logic       en,
  input logic [3:0] busy_nib,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic       wdata0,
  input logic       intrq,
  input logic       ist0
);
  // R2: a strobe always goes out under exactly one chip select
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> ($countones({cs0_n, cs1_n}) == 1));

  // R11: write data still driven on the clock after the write strobe ends, then released
  a_r11_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diow_n) |-> dd_oe);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diow_n) |=> !dd_oe);
  a_r11_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    !dior_n |-> !dd_oe);

  // R8: idle and disabled means nothing is selected next cycle
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && busy_nib == 4'h0) |=> (cs0_n && cs1_n));

  // R7: a zero busy field means the bus is quiet
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_nib == 4'h0) |-> (cs0_n && cs1_n && dior_n && diow_n && !dd_oe));

  // R10: writing 1 clears the device bit when the line is low
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h10 && wdata0 && !intrq) |=> !ist0);
endmodule

bind pio_host_engine pio_host_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n),
  .dior_n(ata_dior_n), .diow_n(ata_diow_n), .dd_oe(ata_dd_oe),
  .en(ctrl_en), .busy_nib(busy_nib), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wdata0(bus_wdata[0]), .intrq(ata_intrq), .ist0(int_stat[0])
);

// File: tb/sim_pio_host_engine.sv
`timescale 1ns/1ps
module sim_pio_host_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, irq;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = 16'hBEEF;
  logic        ata_iordy = 1'b1, ata_intrq = 1'b0;

  always #2.5 clk = ~clk;

  pio_host_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
    .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out),
    .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy), .ata_intrq(ata_intrq),
    .irq(irq)
  );

  typedef struct {
    bit wr; bit cs1; bit [2:0] da; bit [15:0] data; int su; int act; string tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0, errors = 0, pulses = 0;
  int su_n = 0, act_n = 0, gap_n = 0, exp_gap = 0, iordy_rel = 0;
  bit in_pulse = 0, p_wr, p_cs1, p_oe_bad = 0, gap_open = 0, chk_gap = 0;
  bit [2:0]  p_da;
  bit [15:0] p_dd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: measures each bus cycle and compares with the scoreboard
  always @(negedge clk) if (rst_n) begin
    bit cs_any, stb;
    cs_any = !ata_cs0_n || !ata_cs1_n;
    stb    = !ata_dior_n || !ata_diow_n;
    if (stb) begin
      if (!in_pulse) begin
        in_pulse = 1; act_n = 0; p_oe_bad = 0;
        p_wr = !ata_diow_n; p_cs1 = !ata_cs1_n; p_da = ata_da;
      end
      act_n++;
      if (p_wr) p_dd = ata_dd_out;
      if (ata_dd_oe != p_wr) p_oe_bad = 1;
      if (iordy_rel != 0 && act_n == iordy_rel) ata_iordy = 1'b1;
    end else if (in_pulse) begin
      exp_t e;
      in_pulse = 0; pulses++;
      if (p_wr) chk(ata_dd_oe == 1'b1, "R11", "write data hold", ata_dd_oe, 1);
      chk(!p_oe_bad, "R11", "drive during strobe", p_oe_bad, 0);
      if (sbq.size() == 0) chk(0, "R2", "unexpected cycle", pulses, 0);
      else begin
        e = sbq.pop_front();
        chk(p_wr == e.wr, e.tag, "direction", p_wr, e.wr);
        chk(p_cs1 == e.cs1, "R2", "chip select", p_cs1, e.cs1);
        chk(p_da == e.da, "R2", "DA", p_da, e.da);
        if (e.wr) chk(p_dd == e.data, e.tag, "write data", p_dd, e.data);
        chk(su_n == e.su, "R3", "setup clocks", su_n, e.su);
        chk(act_n == e.act, e.tag, "strobe clocks", act_n, e.act);
      end
      su_n = 0; gap_open = 1; gap_n = 1;
    end else if (cs_any) begin
      if (gap_open && chk_gap) chk(gap_n == exp_gap, "R3", "recovery gap", gap_n, exp_gap);
      gap_open = 0; su_n++;
    end else if (gap_open) gap_n++;
  end

  task automatic cpu_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic cpu_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic expect_cyc(input bit wr, input bit cs1, input bit [2:0] da,
                            input bit [15:0] data, input int su, input int act, input string tag);
    exp_t e;
    e.wr = wr; e.cs1 = cs1; e.da = da; e.data = data; e.su = su; e.act = act; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      cpu_rd(8'h90, v);
      if (v[31:28] == 4'h0) return;
    end
    chk(0, "R7", "busy never cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n, "R1", "bus idle", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}, 4'hF);
    chk(!ata_dd_oe && !irq, "R1", "oe/irq low", {ata_dd_oe, irq}, 0);
    cpu_rd(8'h90, v); chk(v == 0, "R1", "status", v, 0);
    cpu_rd(8'h10, v); chk(v == 0, "R1", "int status", v, 0);
    cpu_rd(8'h14, v); chk(v == 3, "R1", "mask", v, 3);

    cpu_wr(8'h2C, 32'h2032);
    cpu_wr(8'h18, 32'h40);
    cpu_wr(8'h00, 32'h1);

    // R2 byte write, R7 busy count
    expect_cyc(1, 0, 2, 16'h00A5, 2, 3, "R2");
    cpu_wr(8'h5C, 32'hFFFF_12A5);
    cpu_rd(8'h90, v); chk(v[31:28] == 1, "R7", "busy nibble", v[31:28], 1);
    wait_idle();
    cpu_rd(8'h90, v); chk(v[31:28] == 0, "R7", "idle nibble", v[31:28], 0);

    // R5 straight and swapped 16-bit writes
    expect_cyc(1, 0, 0, 16'h1234, 2, 3, "R5");
    cpu_wr(8'h54, 32'h1234); wait_idle();
    cpu_wr(8'h18, 32'h0);
    expect_cyc(1, 0, 0, 16'h3412, 2, 3, "R5");
    cpu_wr(8'h54, 32'h1234); wait_idle();
    cpu_wr(8'h18, 32'h40);

    // R2 control block and command offsets
    expect_cyc(1, 1, 6, 16'h0002, 2, 3, "R2");
    cpu_wr(8'h74, 32'h02); wait_idle();
    expect_cyc(1, 0, 7, 16'h00EC, 2, 3, "R2");
    cpu_wr(8'h70, 32'hEC); wait_idle();

    // R4 posted read of a byte register
    expect_cyc(0, 0, 3, 0, 2, 3, "R4");
    cpu_rd(8'h60, v); chk(v == 0, "R4", "launch read value", v, 0);
    wait_idle();
    cpu_rd(8'h7C, v); chk(v == 32'hEF, "R4", "byte result", v, 32'hEF);
    // R5 data port reads
    expect_cyc(0, 0, 0, 0, 2, 3, "R4");
    cpu_rd(8'h54, v); wait_idle();
    cpu_rd(8'h7C, v); chk(v == 32'hBEEF, "R5", "straight read", v, 32'hBEEF);
    cpu_wr(8'h18, 32'h0);
    expect_cyc(0, 0, 0, 0, 2, 3, "R4");
    cpu_rd(8'h54, v); wait_idle();
    cpu_rd(8'h7C, v); chk(v == 32'hEFBE, "R5", "swapped read", v, 32'hEFBE);
    cpu_wr(8'h18, 32'h40);

    // R8 disabled queue, R9 overflow, R3 back-to-back gap
    cpu_wr(8'h00, 32'h0);
    p0 = pulses;
    for (int i = 0; i < 4; i++) expect_cyc(1, 0, 1, 16'(i + 16), 2, 3, "R9");
    for (int i = 0; i < 5; i++) cpu_wr(8'h58, 32'(i + 16));
    repeat (20) @(negedge clk);
    chk(pulses == p0, "R8", "cycles while disabled", pulses, p0);
    cpu_rd(8'h90, v); chk(v[31:28] == 4, "R9", "queue occupancy", v[31:28], 4);
    gap_open = 0; chk_gap = 1; exp_gap = 3;
    cpu_wr(8'h00, 32'h1);
    wait_idle();
    chk_gap = 0;
    chk(pulses == p0 + 4, "R9", "cycles after enable", pulses, p0 + 4);

    // R3 zero counts become one clock
    cpu_wr(8'h2C, 32'h0);
    cpu_wr(8'h00, 32'h0);
    expect_cyc(1, 0, 4, 16'h0011, 1, 1, "R3");
    expect_cyc(1, 0, 5, 16'h0022, 1, 1, "R3");
    cpu_wr(8'h64, 32'h11);
    cpu_wr(8'h68, 32'h22);
    gap_open = 0; chk_gap = 1; exp_gap = 2;
    cpu_wr(8'h00, 32'h1);
    wait_idle();
    chk_gap = 0;

    // R6 IORDY stretch and ignore
    cpu_wr(8'h2C, 32'h2032);
    cpu_wr(8'h18, 32'h42);
    ata_iordy = 1'b0; iordy_rel = 6;
    expect_cyc(1, 0, 2, 16'h0033, 2, 6, "R6");
    cpu_wr(8'h5C, 32'h33); wait_idle();
    iordy_rel = 0; ata_iordy = 1'b0;
    cpu_wr(8'h18, 32'h40);
    expect_cyc(1, 0, 2, 16'h0044, 2, 3, "R6");
    cpu_wr(8'h5C, 32'h44); wait_idle();
    ata_iordy = 1'b1;

    // R10 interrupts
    @(negedge clk); ata_intrq = 1'b1;
    @(negedge clk); ata_intrq = 1'b0;
    cpu_rd(8'h10, v); chk(v == 3, "R10", "status bits set", v, 3);
    chk(irq == 0, "R10", "masked irq", irq, 0);
    cpu_wr(8'h14, 32'h2);
    chk(irq == 1, "R10", "unmasked irq", irq, 1);
    cpu_wr(8'h10, 32'h1);
    chk(irq == 0, "R10", "irq after clear", irq, 0);
    cpu_rd(8'h10, v); chk(v == 2, "R10", "w1c one bit", v, 2);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule